// File: doc/BRIEF.md
# Program-ROM Bank Mapper with Pinned Upper Windows

This block sits between a CPU's 16-bit address bus and a program ROM image. It maps the upper half of the address space, 0x8000 to 0xFFFF, onto byte offsets in the image using 8 KB banks. The CPU window is split into four 8 KB slots. The top slot always shows the last bank. One of the two lower slots is pinned to the bank before the last. The other slots take bank numbers that software writes into two control registers.

The CPU programs the mapper by writing into its own ROM window. A write at an even address in 0x8000 to 0x9FFF goes to the select register. It chooses which bank register the next data write loads, and it carries the mode bit that swaps the pinned and the switchable low slot. A write at an odd address in that range goes to the data register. The ROM size comes in as a static count of 16 KB units, taken from the image header. A static flag adds the 512-byte prefix that some images carry after the 16-byte header. The translation is combinational from the address and the register state. Register writes take effect in the cycle after the clock edge that captures them. The header inputs must stay constant while reset is released.

Top module: `prg_bank_mapper`

## Requirements
- R1: `rom_hit` equals address bit 15. When `rom_hit` is 0 (address below 0x8000), `rom_ofs` is 0.
- R2: Addresses 0xE000 to 0xFFFF map to bank N-1, where N = 2 × `prg_units_16k` is the number of 8 KB banks.
- R3: With mode 0, 0xC000 to 0xDFFF maps to bank N-2, and 0x8000 to 0x9FFF maps to the low bank register.
- R4: With mode 1, 0x8000 to 0x9FFF maps to bank N-2, and 0xC000 to 0xDFFF maps to the low bank register.
- R5: 0xA000 to 0xBFFF maps to the middle bank register in both modes.
- R6: A write at an even address in 0x8000 to 0x9FFF loads the select register. Data bits 2:0 become the target and data bit 6 becomes the mode. The new mode applies from the cycle after the write edge.
- R7: A write at an odd address in 0x8000 to 0x9FFF loads the low bank register when the target is 6, and the middle bank register when the target is 7. With any other target, the data write changes nothing. Writes at addresses outside 0x8000 to 0x9FFF change nothing. Both registers appear at every even and every odd address of that range.
- R8: A written bank number is ANDed with a mask. The mask is all ones from bit 0 up to the highest set bit of N-1.
- R9: `rom_ofs` = base + bank × 8192 + address[12:0]. The base is 16, or 528 when `has_trainer` is 1.
- R10: After reset, the mode is 0, the target is 0, the low bank register holds 0 and the middle bank register holds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe, sampled at the clock edge |
| cpu_wdata | input | DATA_W (8) | CPU write data |
| prg_units_16k | input | HDR_CNT_W (8) | ROM size in 16 KB units (static) |
| has_trainer | input | 1 | Image holds a 512-byte prefix after the header (static) |
| rom_ofs | output | HDR_CNT_W+15 (23) | Byte offset into the ROM image |
| rom_hit | output | 1 | Address falls in the ROM window |

## Verification
A wrong mode bit or bank register does not show up on its own. It appears as a whole 8 KB slot reading the wrong bank. That slot's offset is off by a multiple of 8192 on the first read after the faulty write, and it stays wrong until the register is written again. A wrong mask or a wrong target decode shows up the same way, and only in the slot that uses the affected register. For this reason every register setting is followed by reads of all four slots at their edges and at an interior point. The bank values are swept for both modes and at two ROM sizes.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
    // select-register target codes that load a bank register
    localparam int TGT_LOW = 6;
    localparam int TGT_MID = 7;
    // position of the mode bit in the select byte
    localparam int MODE_BIT = 6;
    // bytes ahead of the ROM data in the image
    localparam int HDR_BYTES     = 16;
    localparam int TRAINER_BYTES = 512;
    // 8 KB slot geometry
    localparam int SLOT_W = 13;

    typedef enum logic [1:0] {
        SLOT_LO  = 2'd0,
        SLOT_MID = 2'd1,
        SLOT_HI  = 2'd2,
        SLOT_TOP = 2'd3
    } slot_e;
endpackage

// File: rtl/prg_reg_file.sv
module prg_reg_file
    import prg_map_pkg::*;
#(
    parameter int BANK_W = 9,
    parameter int DATA_W = 8,
    parameter int TGT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_region,
    input  logic              wr_odd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BANK_W-1:0] bank_cnt,
    output logic              mode,
    output logic [BANK_W-1:0] bank_lo,
    output logic [BANK_W-1:0] bank_mid
);
    typedef struct packed {
        logic [TGT_W-1:0]  tgt;
        logic              mode;
        logic [BANK_W-1:0] lo;
        logic [BANK_W-1:0] mid;
    } regs_t;

    regs_t r_d, r_q;

    logic [BANK_W-1:0] bank_limit;
    logic [BANK_W-1:0] bank_mask;
    logic [BANK_W-1:0] masked;
    logic              in_range;
    logic              sel_wr;
    logic              dat_wr;

    assign bank_limit = bank_cnt - 1'b1;

    for (genvar i = 0; i < BANK_W; i++) begin : g_mask
        assign bank_mask[i] = |bank_limit[BANK_W-1:i];
    end

    assign in_range = (wr_region == 3'b100);
    assign sel_wr   = wr_en && in_range && !wr_odd;
    assign dat_wr   = wr_en && in_range && wr_odd;
    assign masked   = BANK_W'(wr_data) & bank_mask;

    always_comb begin
        r_d = r_q;
        if (sel_wr) begin
            r_d.tgt  = wr_data[TGT_W-1:0];
            r_d.mode = wr_data[MODE_BIT];
        end
        if (dat_wr) begin
            if (r_q.tgt == TGT_W'(TGT_LOW)) begin
                r_d.lo = masked;
            end else if (r_q.tgt == TGT_W'(TGT_MID)) begin
                r_d.mid = masked;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.tgt  <= '0;
            r_q.mode <= 1'b0;
            r_q.lo   <= '0;
            r_q.mid  <= BANK_W'(1);
        end else begin
            r_q <= r_d;
        end
    end

    assign mode     = r_q.mode;
    assign bank_lo  = r_q.lo;
    assign bank_mid = r_q.mid;

    // R7: a data write with a non-bank target leaves both banks untouched
    a_r7_other_target_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && r_q.tgt != TGT_W'(TGT_LOW) && r_q.tgt != TGT_W'(TGT_MID))
        |=> ($stable(bank_lo) && $stable(bank_mid)));

    // R6: the mode only moves on a select write
    a_r6_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(mode));

    // R7: writes outside the register range change no state
    a_r7_out_of_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_range) |=> ($stable(mode) && $stable(bank_lo) && $stable(bank_mid)));

    // R8: a loaded bank never has bits above the mask
    a_r8_loaded_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && r_q.tgt == TGT_W'(TGT_LOW)) |=> ((bank_lo & ~bank_mask) == '0));
endmodule

// File: rtl/prg_slot_sel.sv
module prg_slot_sel
    import prg_map_pkg::*;
#(
    parameter int BANK_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        slot,
    input  logic              mode,
    input  logic [BANK_W-1:0] bank_lo,
    input  logic [BANK_W-1:0] bank_mid,
    input  logic [BANK_W-1:0] bank_cnt,
    output logic [BANK_W-1:0] bank
);
    logic [BANK_W-1:0] bank_last;
    logic [BANK_W-1:0] bank_prev;

    assign bank_last = bank_cnt - BANK_W'(1);
    assign bank_prev = bank_cnt - BANK_W'(2);

    always_comb begin
        unique case (slot_e'(slot))
            SLOT_LO:  bank = mode ? bank_prev : bank_lo;
            SLOT_MID: bank = bank_mid;
            SLOT_HI:  bank = mode ? bank_lo : bank_prev;
            SLOT_TOP: bank = bank_last;
            default:  bank = bank_last;
        endcase
    end

    // R2: the top slot reads one bank below the count
    a_r2_top_slot_last: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == 2'b11) |-> (bank + BANK_W'(1) == bank_cnt));

    // R5: the 0xA000 slot follows the middle register in either mode
    a_r5_mid_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == 2'b01) |-> (bank == bank_mid));

    // R3/R4: exactly one low slot is pinned two below the count
    a_r4_pinned_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot == 2'b00 && mode) || (slot == 2'b10 && !mode)) |-> (bank + BANK_W'(2) == bank_cnt));
endmodule

// File: rtl/prg_ofs_calc.sv
module prg_ofs_calc
    import prg_map_pkg::*;
#(
    parameter int BANK_W = 9,
    parameter int OFS_W  = 23
) (
    input  logic              hit,
    input  logic              trainer,
    input  logic [BANK_W-1:0] bank,
    input  logic [SLOT_W-1:0] inner,
    output logic [OFS_W-1:0]  ofs
);
    localparam logic [OFS_W-1:0] BASE_PLAIN = OFS_W'(HDR_BYTES);
    localparam logic [OFS_W-1:0] BASE_TRAIN = OFS_W'(HDR_BYTES + TRAINER_BYTES);

    logic [OFS_W-1:0] base;
    logic [OFS_W-1:0] raw;

    assign base = trainer ? BASE_TRAIN : BASE_PLAIN;
    assign raw  = OFS_W'({bank, inner});
    assign ofs  = hit ? (base + raw) : '0;
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
    import prg_map_pkg::*;
#(
    parameter int HDR_CNT_W = 8,
    parameter int DATA_W    = 8,
    localparam int BANK_W   = HDR_CNT_W + 1,
    localparam int OFS_W    = BANK_W + SLOT_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          cpu_addr,
    input  logic                 cpu_wr,
    input  logic [DATA_W-1:0]    cpu_wdata,
    input  logic [HDR_CNT_W-1:0] prg_units_16k,
    input  logic                 has_trainer,
    output logic [OFS_W-1:0]     rom_ofs,
    output logic                 rom_hit
);
    logic [BANK_W-1:0] bank_cnt;
    logic              mode;
    logic [BANK_W-1:0] bank_lo;
    logic [BANK_W-1:0] bank_mid;
    logic [BANK_W-1:0] bank_sel;

    assign bank_cnt = {prg_units_16k, 1'b0};
    assign rom_hit  = cpu_addr[15];

    prg_reg_file #(
        .BANK_W (BANK_W),
        .DATA_W (DATA_W),
        .TGT_W  (3)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cpu_wr),
        .wr_region (cpu_addr[15:13]),
        .wr_odd    (cpu_addr[0]),
        .wr_data   (cpu_wdata),
        .bank_cnt  (bank_cnt),
        .mode      (mode),
        .bank_lo   (bank_lo),
        .bank_mid  (bank_mid)
    );

    prg_slot_sel #(
        .BANK_W (BANK_W)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot     (cpu_addr[14:13]),
        .mode     (mode),
        .bank_lo  (bank_lo),
        .bank_mid (bank_mid),
        .bank_cnt (bank_cnt),
        .bank     (bank_sel)
    );

    prg_ofs_calc #(
        .BANK_W (BANK_W),
        .OFS_W  (OFS_W)
    ) u_ofs (
        .hit     (rom_hit),
        .trainer (has_trainer),
        .bank    (bank_sel),
        .inner   (cpu_addr[SLOT_W-1:0]),
        .ofs     (rom_ofs)
    );

    // R1: low addresses never hit and produce a zero offset
    a_r1_low_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[15] |-> (!rom_hit && rom_ofs == '0));

    // R9: an in-window offset is never below the image base
    a_r9_above_base: assert property (@(posedge clk) disable iff (!rst_n)
        rom_hit |-> (rom_ofs >= OFS_W'(HDR_BYTES)));
endmodule

// File: tb/prg_bank_mapper_tb.sv
module prg_bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  prg_units_16k = 8'd4;
    logic        has_trainer = 1'b0;
    logic [22:0] rom_ofs;
    logic        rom_hit;

    int nchecks = 0;
    int nerrors = 0;
    bit done = 1'b0;

    // bench model of the register state
    int m_mode, m_lo, m_mid, m_tgt;

    always #4 clk = ~clk;

    prg_bank_mapper u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_addr      (cpu_addr),
        .cpu_wr        (cpu_wr),
        .cpu_wdata     (cpu_wdata),
        .prg_units_16k (prg_units_16k),
        .has_trainer   (has_trainer),
        .rom_ofs       (rom_ofs),
        .rom_hit       (rom_hit)
    );

    function automatic int bank_mask();
        int n = 2 * int'(prg_units_16k);
        int m = 0;
        while (m < n - 1) m = m * 2 + 1;
        return m;
    endfunction

    function automatic int exp_ofs(int a);
        int n = 2 * int'(prg_units_16k);
        int b;
        int base = has_trainer ? 528 : 16;
        if (a < 32768) return 0;
        case ((a >> 13) & 3)
            0: b = m_mode ? n - 2 : m_lo;
            1: b = m_mid;
            2: b = m_mode ? m_lo : n - 2;
            default: b = n - 1;
        endcase
        return base + b * 8192 + (a & 8191);
    endfunction

    task automatic chk(input logic [15:0] a, input string tag);
        int e;
        bit eh;
        cpu_addr = a;
        #1;
        e  = exp_ofs(int'(a));
        eh = a[15];
        nchecks++;
        if (int'(rom_ofs) != e || rom_hit != eh) begin
            nerrors++;
            $display("FAIL %s addr=%h ofs=%0d exp=%0d hit=%b exp=%b", tag, a, rom_ofs, e, rom_hit, eh);
        end
    endtask

    task automatic sweep(input string tag);
        for (int s = 0; s < 4; s++) begin
            chk(16'(32768 + s * 8192), tag);
            chk(16'(32768 + s * 8192 + 1), tag);
            chk(16'(32768 + s * 8192 + 2748), tag);
            chk(16'(32768 + s * 8192 + 8191), tag);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cpu_addr  = 16'(a);
        cpu_wdata = 8'(d);
        cpu_wr    = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a >= 32768 && a < 40960) begin
            if ((a & 1) == 0) begin
                m_tgt  = d & 7;
                m_mode = (d >> 6) & 1;
            end else if (m_tgt == 6) begin
                m_lo = d & bank_mask();
            end else if (m_tgt == 7) begin
                m_mid = d & bank_mask();
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        m_mode = 0; m_lo = 0; m_mid = 1; m_tgt = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerrors++;
            nchecks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: reset state (low slot bank 0, middle slot bank 1, mode 0)
        sweep("R10");

        // R1: whole lower half misses with zero offset
        for (int a = 0; a < 32768; a += 256) chk(16'(a), "R1");
        chk(16'h7FFF, "R1");

        // R3/R4/R5/R2: sweep every bank value in both modes
        for (int md = 0; md < 2; md++) begin
            for (int v = 0; v < 8; v++) begin
                wr(32768, (md << 6) | 6);
                wr(32769, v);
                wr(32768, (md << 6) | 7);
                wr(32769, 7 - v);
                sweep(md ? "R4/R5/R2" : "R3/R5/R2");
            end
        end

        // R8: values above the bank count are masked
        wr(32768, 6);
        wr(32769, 255);
        wr(32768, 7);
        wr(32769, 11);
        sweep("R8");

        // R6/R7: mirrored register addresses across 0x8000-0x9FFF
        wr(40958, 8'h47);
        wr(36611, 2);
        sweep("R6/R7 mirror");
        wr(34000, 8'h06);
        wr(39999, 5);
        sweep("R6 mode back to 0");

        // R7: targets 0..5 ignore data writes
        for (int t = 0; t < 6; t++) begin
            wr(32768, t);
            wr(32769, 4);
            sweep("R7 target ignored");
        end
        // R7: writes outside the register range
        wr(32768, 6);
        wr(40961, 3);
        wr(49152, 8'h40);
        wr(57345, 1);
        wr(32767, 8'h40);
        wr(1, 2);
        sweep("R7 range ignored");

        // R9: trainer base and a non-power-of-two size
        prg_units_16k = 8'd3;
        has_trainer   = 1'b1;
        do_reset();
        sweep("R9 trainer reset");
        for (int v = 0; v < 8; v++) begin
            wr(32768, 8'h46);
            wr(32769, v + 8);
            wr(32768, 7);
            wr(32769, v);
            sweep("R9/R8 trainer");
        end
        chk(16'h7FFF, "R1 trainer");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
        $finish;
    end
endmodule